// File: doc/BRIEF.md
# Channel-Steered Cell Reassembly Engine

This block turns a stream of fixed 48-byte cells into whole messages for a set of receiving endpoints. Every cell carries a channel number and an end-of-message flag. A small mapping table turns the channel number into an endpoint. A multi-cell message takes one receive buffer from that endpoint's pool of free buffer addresses when its opening cell arrives. The block then writes each cell of the message into that buffer at increasing byte offsets. When the closing cell arrives, it issues a completion descriptor. A message of only one cell takes no buffer: the cell itself travels inside the descriptor, which is marked as inline.

Each channel keeps its own reassembly state, so messages on different channels may interleave cell by cell. The integrity result of the whole message is computed outside the block and comes in alongside the closing cell as a pass/fail bit. A failed result is copied into the descriptor as an error flag, and the buffer is still returned. Two conditions discard traffic. A cell on an unmapped channel is thrown away. A message that finds its endpoint's pool empty is thrown away up to and including its closing cell. Each condition has its own counter.

The cell input, the free-buffer input and the descriptor output are valid/ready streams: a transfer happens on a rising clock edge where both valid and ready are high. The descriptor output is held stable while `rd_ready` is low, and `cell_ready` is low whenever a descriptor is waiting. The buffer-write port and the mapping-table write port are plain strobes that are always accepted.

Top module: `cell_reasm`

## Requirements
- R1: A cell whose channel has no valid mapping entry is discarded: it causes no buffer write and no descriptor, and `unknown_count` rises by exactly 1 on the following cycle. A mapping write takes effect for cells accepted after the cycle in which it is written.
- R2: An opening cell of a multi-cell message (channel idle, `cell_last`=0) takes the oldest address from its endpoint's free pool. One cycle after acceptance, `mem_we` pulses with `mem_addr` equal to that address and `mem_data` equal to the cell.
- R3: Each further cell of that message is written one cycle after acceptance at the buffer address plus 48 times the number of cells already stored.
- R4: A closing cell (channel busy, `cell_last`=1) is written like R3 and also produces, one cycle after acceptance, a descriptor with `rd_inline`=0, `rd_addr` equal to the buffer address, `rd_len` equal to 48 times the cell count, the channel and endpoint, and `rd_err` equal to the inverse of `cell_crc_ok`.
- R5: A single-cell message (channel idle, `cell_last`=1) produces a descriptor with `rd_inline`=1, `rd_len`=48, `rd_addr`=0, `rd_data` equal to the cell and `rd_err` equal to the inverse of `cell_crc_ok`. It takes no pool entry and causes no buffer write.
- R6: An opening cell that finds its endpoint's pool empty raises `drop_count` by 1. Every cell of that message through its closing cell is then discarded without writes or descriptors, and the channel is idle again after the closing cell.
- R7: Reassembly state is held separately for each of 16 channels, so interleaved messages on different channels each keep their own buffer and offset.
- R8: A descriptor stays valid, with unchanged fields, until it is taken with `rd_ready`. `cell_ready` equals `!rd_valid || rd_ready`.
- R9: Each endpoint pool holds 4 addresses and returns them in the order they were pushed. `fb_ready` is low exactly when the pool selected by `fb_ep` is full, and a push is taken only when `fb_ready` is high.
- R10: After reset, `mem_we`, `rd_valid` and both counters are 0, every mapping entry is invalid, every channel is idle and every pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Cell offered |
| cell_ready | output | 1 | Cell accepted when high with cell_valid |
| cell_vc | input | 4 | Channel number of the cell |
| cell_last | input | 1 | Cell closes its message |
| cell_crc_ok | input | 1 | External integrity result, read with the closing cell |
| cell_data | input | 384 | Cell payload, 48 bytes |
| map_we | input | 1 | Mapping table write strobe |
| map_vc | input | 4 | Channel entry to write |
| map_valid | input | 1 | Entry valid bit to store |
| map_ep | input | 2 | Endpoint to store |
| fb_valid | input | 1 | Free buffer address offered |
| fb_ready | output | 1 | Selected pool has room |
| fb_ep | input | 2 | Pool the address belongs to |
| fb_addr | input | 16 | Free buffer byte address |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 16 | Buffer write byte address |
| mem_data | output | 384 | Buffer write data |
| rd_valid | output | 1 | Descriptor valid |
| rd_ready | input | 1 | Descriptor taken |
| rd_ep | output | 2 | Destination endpoint |
| rd_vc | output | 4 | Channel number |
| rd_len | output | 16 | Message length in bytes |
| rd_addr | output | 16 | Buffer address, 0 when inline |
| rd_inline | output | 1 | Payload is in rd_data |
| rd_err | output | 1 | Integrity check failed |
| rd_data | output | 384 | Inline payload, zero otherwise |
| drop_count | output | 16 | Messages dropped for lack of a buffer |
| unknown_count | output | 16 | Cells on unmapped channels |

## Verification
The hardest situations to reach from the ports are a message that is dropped mid-stream and two messages whose cells interleave on different channels. Both depend on the order of pool refills relative to opening cells. The stimulus therefore drains one endpoint's pool with earlier messages before it starts a three-cell message, then refills the pool and checks that the same channel reassembles normally. A separate sequence alternates cells of two channels that map to different endpoints, and another holds `rd_ready` low while a second cell waits, so that stall and hold behaviour is compared cycle by cycle against the behavioural model.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
  // Classification of an accepted cell against its channel state
  typedef enum logic [2:0] {
    CK_UNKNOWN,
    CK_SINGLE,
    CK_FIRST,
    CK_MIDDLE,
    CK_FINAL,
    CK_DROP,
    CK_NOBUF
  } cell_kind_e;
endpackage

// File: rtl/reasm_vc_table.sv
module reasm_vc_table #(
  parameter int NUM_VC = 16,
  parameter int NUM_EP = 4,
  localparam int VC_W = $clog2(NUM_VC),
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [VC_W-1:0] wvc,
  input  logic            wvalid,
  input  logic [EP_W-1:0] wep,
  input  logic [VC_W-1:0] rvc,
  output logic            hit,
  output logic [EP_W-1:0] ep
);
  logic [NUM_VC-1:0] valid_q;
  logic [EP_W-1:0]   ep_q [NUM_VC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_VC; i++) ep_q[i] <= '0;
    end else if (we) begin
      valid_q[wvc] <= wvalid;
      ep_q[wvc]    <= wep;
    end
  end

  assign hit = valid_q[rvc];
  assign ep  = ep_q[rvc];
endmodule

// File: rtl/reasm_free_fifo.sv
module reasm_free_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  assign head  = slot[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  AST_FQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_FQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R2
endmodule

// File: rtl/cell_reasm.sv
module cell_reasm
  import reasm_pkg::*;
#(
  parameter int CELL_BYTES = 48,
  parameter int NUM_VC     = 16,
  parameter int NUM_EP     = 4,
  parameter int FQ_DEPTH   = 4,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 16,
  localparam int CELL_W = 8 * CELL_BYTES,
  localparam int VC_W   = $clog2(NUM_VC),
  localparam int EP_W   = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [VC_W-1:0]   cell_vc,
  input  logic              cell_last,
  input  logic              cell_crc_ok,
  input  logic [CELL_W-1:0] cell_data,
  input  logic              map_we,
  input  logic [VC_W-1:0]   map_vc,
  input  logic              map_valid,
  input  logic [EP_W-1:0]   map_ep,
  input  logic              fb_valid,
  output logic              fb_ready,
  input  logic [EP_W-1:0]   fb_ep,
  input  logic [ADDR_W-1:0] fb_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CELL_W-1:0] mem_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [EP_W-1:0]   rd_ep,
  output logic [VC_W-1:0]   rd_vc,
  output logic [LEN_W-1:0]  rd_len,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_inline,
  output logic              rd_err,
  output logic [CELL_W-1:0] rd_data,
  output logic [CNT_W-1:0]  drop_count,
  output logic [CNT_W-1:0]  unknown_count
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(CELL_BYTES);

  logic            take;
  logic            hit;
  logic [EP_W-1:0] ep_sel;
  cell_kind_e      kind;

  logic [NUM_EP-1:0] fq_full, fq_empty, fq_push, fq_pop;
  logic [ADDR_W-1:0] fq_head [NUM_EP];

  logic [NUM_VC-1:0] ch_busy, ch_drop;
  logic [ADDR_W-1:0] ch_base [NUM_VC];
  logic [LEN_W-1:0]  ch_off  [NUM_VC];

  assign cell_ready = !rd_valid || rd_ready;
  assign take       = cell_valid && cell_ready;
  assign fb_ready   = !fq_full[fb_ep];

  reasm_vc_table #(.NUM_VC(NUM_VC), .NUM_EP(NUM_EP)) u_map (
    .clk(clk), .rst_n(rst_n),
    .we(map_we), .wvc(map_vc), .wvalid(map_valid), .wep(map_ep),
    .rvc(cell_vc), .hit(hit), .ep(ep_sel)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_pool
    assign fq_push[e] = fb_valid && fb_ready && (fb_ep == EP_W'(e));
    assign fq_pop[e]  = take && (kind == CK_FIRST) && (ep_sel == EP_W'(e));
    reasm_free_fifo #(.DEPTH(FQ_DEPTH), .AW(ADDR_W)) u_fq (
      .clk(clk), .rst_n(rst_n),
      .push(fq_push[e]), .push_addr(fb_addr), .pop(fq_pop[e]),
      .head(fq_head[e]), .full(fq_full[e]), .empty(fq_empty[e])
    );
  end

  // Decide what the current cell means for its channel
  always_comb begin
    if (!hit)                  kind = CK_UNKNOWN;
    else if (ch_drop[cell_vc]) kind = CK_DROP;
    else if (!ch_busy[cell_vc]) begin
      if (cell_last)             kind = CK_SINGLE;
      else if (fq_empty[ep_sel]) kind = CK_NOBUF;
      else                       kind = CK_FIRST;
    end else                   kind = cell_last ? CK_FINAL : CK_MIDDLE;
  end

  // Per-channel reassembly state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_busy <= '0;
      ch_drop <= '0;
      for (int i = 0; i < NUM_VC; i++) begin
        ch_base[i] <= '0;
        ch_off[i]  <= '0;
      end
    end else if (take) begin
      case (kind)
        CK_FIRST: begin
          ch_busy[cell_vc] <= 1'b1;
          ch_base[cell_vc] <= fq_head[ep_sel];
          ch_off[cell_vc]  <= STEP;
        end
        CK_MIDDLE: ch_off[cell_vc] <= ch_off[cell_vc] + STEP;
        CK_FINAL: begin
          ch_busy[cell_vc] <= 1'b0;
          ch_off[cell_vc]  <= '0;
        end
        CK_NOBUF: ch_drop[cell_vc] <= 1'b1;
        CK_DROP:  if (cell_last) ch_drop[cell_vc] <= 1'b0;
        default: ;
      endcase
    end
  end

  // Buffer write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= take && (kind == CK_FIRST || kind == CK_MIDDLE || kind == CK_FINAL);
      if (take) begin
        mem_addr <= (kind == CK_FIRST) ? fq_head[ep_sel]
                                       : ch_base[cell_vc] + ADDR_W'(ch_off[cell_vc]);
        mem_data <= cell_data;
      end
    end
  end

  // Descriptor output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_ep     <= '0;
      rd_vc     <= '0;
      rd_len    <= '0;
      rd_addr   <= '0;
      rd_inline <= 1'b0;
      rd_err    <= 1'b0;
      rd_data   <= '0;
    end else if (take && (kind == CK_SINGLE || kind == CK_FINAL)) begin
      rd_valid  <= 1'b1;
      rd_ep     <= ep_sel;
      rd_vc     <= cell_vc;
      rd_inline <= (kind == CK_SINGLE);
      rd_err    <= !cell_crc_ok;
      rd_len    <= (kind == CK_SINGLE) ? STEP : ch_off[cell_vc] + STEP;
      rd_addr   <= (kind == CK_SINGLE) ? '0 : ch_base[cell_vc];
      rd_data   <= (kind == CK_SINGLE) ? cell_data : '0;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  // Discard counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_count    <= '0;
      unknown_count <= '0;
    end else if (take) begin
      if (kind == CK_NOBUF)   drop_count    <= drop_count + 1'b1;
      if (kind == CK_UNKNOWN) unknown_count <= unknown_count + 1'b1;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_len) && $stable(rd_addr) && $stable(rd_vc)); // R8
  AST_INLINE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_inline |-> rd_len == STEP && rd_addr == '0); // R5
  AST_SINGLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && kind == CK_SINGLE |=> !mem_we); // R5
  AST_BUF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_inline |-> rd_len >= 2 * STEP); // R4
  AST_UNKNOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (unknown_count == $past(unknown_count) || unknown_count == $past(unknown_count) + 1'b1)); // R1
endmodule

// File: tb/sim_cell_reasm.sv
module sim_cell_reasm;
  localparam int CB = 48;
  localparam int CW = 8 * CB;

  logic clk = 0, rst_n = 0;
  logic cell_valid = 0, cell_last = 0, cell_crc_ok = 0;
  logic [3:0] cell_vc = 0;
  logic [CW-1:0] cell_data = '0;
  logic cell_ready;
  logic map_we = 0, map_valid = 0;
  logic [3:0] map_vc = 0;
  logic [1:0] map_ep = 0;
  logic fb_valid = 0, fb_ready;
  logic [1:0] fb_ep = 0;
  logic [15:0] fb_addr = 0;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [CW-1:0] mem_data;
  logic rd_valid, rd_ready = 1, rd_inline, rd_err;
  logic [1:0] rd_ep;
  logic [3:0] rd_vc;
  logic [15:0] rd_len, rd_addr, drop_count, unknown_count;
  logic [CW-1:0] rd_data;

  cell_reasm u0 (.*);

  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  string phase = "R10";

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (during %s) %s: got %0h expected %0h", req, phase, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_val[16];
  int m_ep[16];
  int fq[4][$];
  bit c_busy[16], c_drop[16];
  int c_base[16], c_off[16];
  bit e_we = 0; int e_waddr = 0; logic [CW-1:0] e_wdata = '0; string e_wtag = "R2";
  bit e_rv = 0; int e_rep = 0, e_rvc = 0, e_rlen = 0, e_raddr = 0;
  bit e_rin = 0, e_rerr = 0; logic [CW-1:0] e_rdata = '0; string e_rtag = "R4";
  int e_drop = 0, e_unk = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ready, fb_ok, take;
      e_ready = !e_rv || rd_ready;
      fb_ok = fq[fb_ep].size() < 4;
      chk(cell_ready == e_ready, "R8", "cell_ready", cell_ready, e_ready);
      chk(fb_ready == fb_ok, "R9", "fb_ready", fb_ready, fb_ok);
      chk(mem_we == e_we, e_wtag, "mem_we", mem_we, e_we);
      if (e_we && mem_we) begin
        chk(mem_addr == 16'(e_waddr), e_wtag, "mem_addr", mem_addr, e_waddr);
        chk(mem_data == e_wdata, e_wtag, "mem_data", mem_data[63:0], e_wdata[63:0]);
      end
      chk(rd_valid == e_rv, e_rtag, "rd_valid", rd_valid, e_rv);
      if (e_rv && rd_valid) begin
        chk(rd_ep == 2'(e_rep), e_rtag, "rd_ep", rd_ep, e_rep);
        chk(rd_vc == 4'(e_rvc), e_rtag, "rd_vc", rd_vc, e_rvc);
        chk(rd_len == 16'(e_rlen), e_rtag, "rd_len", rd_len, e_rlen);
        chk(rd_addr == 16'(e_raddr), e_rtag, "rd_addr", rd_addr, e_raddr);
        chk(rd_inline == e_rin, e_rtag, "rd_inline", rd_inline, e_rin);
        chk(rd_err == e_rerr, e_rtag, "rd_err", rd_err, e_rerr);
        if (e_rin) chk(rd_data == e_rdata, "R5", "rd_data", rd_data[63:0], e_rdata[63:0]);
      end
      chk(unknown_count == 16'(e_unk), "R1", "unknown_count", unknown_count, e_unk);
      chk(drop_count == 16'(e_drop), "R6", "drop_count", drop_count, e_drop);

      // predict the coming edge
      take = cell_valid && e_ready;
      if (e_rv && rd_ready) e_rv = 0;
      e_we = 0;
      if (take) begin
        int v, ep;
        v = cell_vc;
        if (!m_val[v]) e_unk++;
        else begin
          ep = m_ep[v];
          if (c_drop[v]) begin
            if (cell_last) c_drop[v] = 0;
          end else if (!c_busy[v]) begin
            if (cell_last) begin
              e_rv = 1; e_rep = ep; e_rvc = v; e_rlen = CB; e_raddr = 0;
              e_rin = 1; e_rerr = !cell_crc_ok; e_rdata = cell_data; e_rtag = "R5";
            end else if (fq[ep].size() == 0) begin
              c_drop[v] = 1; e_drop++;
            end else begin
              c_base[v] = fq[ep].pop_front(); c_busy[v] = 1; c_off[v] = CB;
              e_we = 1; e_waddr = c_base[v]; e_wdata = cell_data; e_wtag = "R2";
            end
          end else begin
            e_we = 1; e_waddr = (c_base[v] + c_off[v]) & 16'hFFFF;
            e_wdata = cell_data; e_wtag = "R3";
            c_off[v] += CB;
            if (cell_last) begin
              e_rv = 1; e_rep = ep; e_rvc = v; e_rlen = c_off[v]; e_raddr = c_base[v];
              e_rin = 0; e_rerr = !cell_crc_ok; e_rdata = '0; e_rtag = "R4";
              c_busy[v] = 0; c_off[v] = 0;
            end
          end
        end
      end
      if (map_we) begin m_val[map_vc] = map_valid; m_ep[map_vc] = map_ep; end
      if (fb_valid && fb_ok) fq[fb_ep].push_back(int'(fb_addr));
    end
  end

  function automatic logic [CW-1:0] mk(int seed);
    logic [CW-1:0] d;
    for (int i = 0; i < CW / 32; i++) d[i*32 +: 32] = 32'(seed * 32'h9E3779B1 + i * 7);
    return d;
  endfunction

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(int vc, bit last, bit ok, int seed);
    bit acc;
    cell_vc = 4'(vc); cell_last = last; cell_crc_ok = ok; cell_data = mk(seed); cell_valid = 1;
    do begin
      @(negedge clk); acc = cell_ready;
      @(posedge clk);
    end while (!acc);
    #2 cell_valid = 0;
  endtask

  task automatic map(int vc, bit val, int ep);
    map_vc = 4'(vc); map_valid = val; map_ep = 2'(ep); map_we = 1;
    idle(1);
    map_we = 0;
  endtask

  task automatic give(int ep, int addr);
    fb_ep = 2'(ep); fb_addr = 16'(addr); fb_valid = 1;
    idle(1);
    fb_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R10 watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // unmapped channel
    phase = "R1";
    send(3, 1, 1, 1);
    idle(2);
    map(0, 1, 1); map(5, 1, 2); map(9, 1, 1);
    give(1, 16'h0100); give(1, 16'h0400); give(2, 16'h0800);
    // inline messages, good and bad integrity
    phase = "R5";
    send(5, 1, 1, 2);
    send(5, 1, 0, 3);
    idle(2);
    // three-cell message with failed integrity
    phase = "R4";
    send(0, 0, 1, 4); send(0, 0, 1, 5); send(0, 1, 0, 6);
    idle(2);
    // interleaved channels
    phase = "R7";
    send(9, 0, 1, 7); send(5, 0, 1, 8); send(9, 0, 1, 9);
    send(5, 1, 1, 10); send(9, 1, 1, 11);
    idle(2);
    // pool for endpoint 1 is now empty
    phase = "R6";
    send(0, 0, 1, 12); send(0, 0, 1, 13); send(0, 1, 1, 14);
    idle(2);
    give(1, 16'h0200);
    send(0, 0, 1, 15); send(0, 1, 1, 16);
    idle(2);
    // overfill pool of endpoint 3, then consume in order
    phase = "R9";
    for (int i = 0; i < 6; i++) give(3, 16'h1000 + i * 16'h40);
    map(2, 1, 3);
    send(2, 0, 1, 17); send(2, 1, 1, 18);
    send(2, 0, 1, 19); send(2, 1, 1, 20);
    idle(2);
    // descriptor back-pressure
    phase = "R8";
    rd_ready = 0;
    send(5, 1, 1, 21);
    fork
      send(5, 1, 0, 22);
      begin idle(5); rd_ready = 1; end
    join
    idle(3);
    // mapping removed
    phase = "R1";
    map(5, 0, 0);
    send(5, 1, 1, 23);
    idle(3);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule